// File: doc/BRIEF.md
# Serial Sharer-Chain Invalidation Engine

This block is the directory side of one memory line whose sharers form a singly linked chain of cache identifiers. Memory keeps a single head pointer for the line. Each cache's link to the cache after it is held in a small table inside the block, one entry per cache. A read from a cache that is not yet a sharer pushes that cache onto the front of the chain.

A write turns the requester into the sole owner. If the writer is already on the chain, it first splices itself out, whether it sits at the head, in the middle or at the tail. It then takes the head pointer at memory. Next, it chases the remaining chain one node at a time. Each node receives an invalidate and answers through a valid/ready acknowledgement, and the acknowledged node's stored successor becomes the next target. When the successor is the null pointer, the writer is granted exclusive ownership and becomes the only member of the chain.

Only one write sequence runs at a time. While it runs, the block reports busy and drops any new request.

Top module: `llinv_seq`

## Requirements
- R1: After reset, `head_ptr` is 0 (the null pointer), and `busy`, `inv_valid`, `ack_ready` and `grant_valid` are all low.
- R2: Cache IDs run from 1 to N_CACHE. A read request (`req_write`=0) from a cache that is not on the chain makes it the new head: `head_ptr` equals that ID in the cycle after the request, and the old head becomes its successor.
- R3: Any request is ignored and leaves `head_ptr` and the chain unchanged in two cases: a read from a cache already on the chain, and a request carrying ID 0.
- R4: A write request (`req_write`=1) raises `busy` in the cycle after it is accepted. `busy` stays high until the cycle after the grant. Requests presented while `busy` is high are ignored.
- R5: A writer that is already on the chain removes itself before the walk starts, and its predecessor is linked to its successor. The writer itself is never sent an invalidate.
- R6: Invalidates go out one at a time, in chain order starting from the head. The first one appears on `inv_valid`/`inv_id` two cycles after the write request.
- R7: `inv_valid` and `inv_id` hold steady until an acknowledgement is taken (`ack_valid` while `ack_ready`). `ack_ready` is high exactly while `inv_valid` is. The next target, which is the acknowledged cache's successor, is presented in the cycle after the acknowledgement.
- R8: A successor of 0 ends the walk. `grant_valid` pulses for one cycle, with `grant_id` set to the writer. This happens in the cycle after the last acknowledgement, or three cycles after the request when no other sharer exists. At the grant, `head_ptr` equals the writer, and the writer is the chain's only member.
- R9: `ack_valid` has no effect when no invalidate is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write (ownership) request, 0 = read (join) request |
| req_id | input | PTR_W | Requesting cache ID (1..N_CACHE) |
| busy | output | 1 | A write sequence is in progress |
| inv_valid | output | 1 | Invalidate outstanding |
| inv_id | output | PTR_W | Cache being invalidated |
| ack_ready | output | 1 | Acknowledgement can be taken |
| ack_valid | input | 1 | Acknowledgement from the invalidated cache |
| grant_valid | output | 1 | One-cycle exclusive-ownership grant |
| grant_id | output | PTR_W | Cache receiving ownership |
| head_ptr | output | PTR_W | Chain head pointer held at memory (0 = empty) |

## Verification
Each result is due at a fixed cycle:
- A read moves `head_ptr` one cycle after its request.
- A write raises `busy` one cycle after its request and shows its first invalidate one cycle later.
- Each new target appears one cycle after its acknowledgement.
- The grant pulse comes one cycle after the final acknowledgement, or three cycles after the request when no other sharer exists.

The bench drives every input on falling edges and samples outputs at the falling edge where each result is due, never at some later poll. It checks the `inv_id` order against a chain it builds itself from its own sequence of joins and writes. Acknowledgement delays vary, and the invalidate is re-checked in every waiting cycle to confirm it holds steady.

// File: rtl/llinv_pkg.sv
package llinv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_UNLINK = 2'd1,
    ST_WALK   = 2'd2,
    ST_GRANT  = 2'd3
  } llinv_state_e;
endpackage

// File: rtl/llinv_table.sv
// Per-cache successor table: entry i describes cache ID i+1.
module llinv_table #(
  parameter int N_CACHE = 6,
  parameter int PTR_W   = $clog2(N_CACHE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] lk_id,
  output logic             lk_present,
  output logic [PTR_W-1:0] lk_next,
  output logic             pred_hit,
  output logic [PTR_W-1:0] pred_id,
  input  logic [PTR_W-1:0] cur_id,
  output logic [PTR_W-1:0] cur_next,
  input  logic             wa_en,
  input  logic [PTR_W-1:0] wa_idx,
  input  logic [PTR_W-1:0] wa_next,
  input  logic             wa_pres,
  input  logic             wb_en,
  input  logic [PTR_W-1:0] wb_idx,
  input  logic [PTR_W-1:0] wb_next,
  input  logic             wb_pres
);
  localparam logic [PTR_W-1:0] NULLP = '0;

  logic [PTR_W-1:0] nxt_q    [N_CACHE];
  logic [N_CACHE-1:0] pres_q;
  logic [PTR_W-1:0] nxt_d    [N_CACHE];
  logic [N_CACHE-1:0] pres_d;
  logic [N_CACHE-1:0] ent_we;
  logic [N_CACHE-1:0] pred_vec;

  for (genvar g = 0; g < N_CACHE; g++) begin : gen_ent
    localparam logic [PTR_W-1:0] ENT_ID = PTR_W'(g + 1);
    logic hit_a, hit_b;
    assign hit_a       = wa_en && (wa_idx == ENT_ID);
    assign hit_b       = wb_en && (wb_idx == ENT_ID);
    assign ent_we[g]   = hit_a || hit_b;
    assign nxt_d[g]    = hit_b ? wb_next : wa_next;
    assign pres_d[g]   = hit_b ? wb_pres : wa_pres;
    assign pred_vec[g] = pres_q[g] && (nxt_q[g] == lk_id) && (lk_id != NULLP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
      for (int i = 0; i < N_CACHE; i++) nxt_q[i] <= NULLP;
    end else begin
      for (int i = 0; i < N_CACHE; i++) begin
        if (ent_we[i]) begin
          nxt_q[i]  <= nxt_d[i];
          pres_q[i] <= pres_d[i];
        end
      end
    end
  end

  always_comb begin
    lk_present = 1'b0;
    lk_next    = NULLP;
    cur_next   = NULLP;
    pred_hit   = 1'b0;
    pred_id    = NULLP;
    for (int i = 0; i < N_CACHE; i++) begin
      if (PTR_W'(i + 1) == lk_id) begin
        lk_present = pres_q[i];
        lk_next    = nxt_q[i];
      end
      if (PTR_W'(i + 1) == cur_id) cur_next = nxt_q[i];
      if (pred_vec[i]) begin
        pred_hit = 1'b1;
        pred_id  = PTR_W'(i + 1);
      end
    end
  end

  // R5: a splice never targets the entry being cleared
  p_ports_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_idx != wb_idx));
  // R5: a well-formed chain has at most one predecessor per node
  p_single_pred_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pred_vec));
endmodule

// File: rtl/llinv_ctrl.sv
module llinv_ctrl
  import llinv_pkg::*;
#(
  parameter int N_CACHE = 6,
  parameter int PTR_W   = $clog2(N_CACHE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [PTR_W-1:0] req_id,
  input  logic             ack_valid,
  output logic             busy,
  output logic             inv_valid,
  output logic [PTR_W-1:0] inv_id,
  output logic             ack_ready,
  output logic             grant_valid,
  output logic [PTR_W-1:0] grant_id,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] lk_id,
  input  logic             lk_present,
  input  logic [PTR_W-1:0] lk_next,
  input  logic             pred_hit,
  input  logic [PTR_W-1:0] pred_id,
  output logic [PTR_W-1:0] cur_id,
  input  logic [PTR_W-1:0] cur_next,
  output logic             wa_en,
  output logic [PTR_W-1:0] wa_idx,
  output logic [PTR_W-1:0] wa_next,
  output logic             wa_pres,
  output logic             wb_en,
  output logic [PTR_W-1:0] wb_idx,
  output logic [PTR_W-1:0] wb_next,
  output logic             wb_pres
);
  localparam logic [PTR_W-1:0] NULLP = '0;
  localparam logic [PTR_W-1:0] MAXID = PTR_W'(N_CACHE);

  llinv_state_e     state_q, state_d;
  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] wr_q, wr_d;
  logic [PTR_W-1:0] cur_q, cur_d;
  logic             id_ok;

  assign id_ok = (req_id != NULLP) && (req_id <= MAXID);
  assign lk_id = (state_q == ST_IDLE) ? req_id : wr_q;
  assign cur_id = cur_q;

  always_comb begin
    state_d = state_q;
    head_d  = head_q;
    wr_d    = wr_q;
    cur_d   = cur_q;
    wa_en = 1'b0; wa_idx = NULLP; wa_next = NULLP; wa_pres = 1'b0;
    wb_en = 1'b0; wb_idx = NULLP; wb_next = NULLP; wb_pres = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && id_ok) begin
          if (req_write) begin
            wr_d    = req_id;
            state_d = ST_UNLINK;
          end else if (!lk_present) begin
            wa_en   = 1'b1;
            wa_idx  = req_id;
            wa_next = head_q;
            wa_pres = 1'b1;
            head_d  = req_id;
          end
        end
      end
      ST_UNLINK: begin
        cur_d = head_q;
        if (lk_present) begin
          wa_en  = 1'b1;
          wa_idx = wr_q;
          if (head_q == wr_q) begin
            cur_d = lk_next;
          end else if (pred_hit) begin
            wb_en   = 1'b1;
            wb_idx  = pred_id;
            wb_next = lk_next;
            wb_pres = 1'b1;
          end
        end
        head_d  = wr_q;
        state_d = ST_WALK;
      end
      ST_WALK: begin
        if (cur_q == NULLP) begin
          state_d = ST_GRANT;
        end else if (ack_valid) begin
          wa_en  = 1'b1;
          wa_idx = cur_q;
          cur_d  = cur_next;
          if (cur_next == NULLP) state_d = ST_GRANT;
        end
      end
      ST_GRANT: begin
        wa_en   = 1'b1;
        wa_idx  = wr_q;
        wa_pres = 1'b1;
        cur_d   = NULLP;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      head_q  <= NULLP;
      wr_q    <= NULLP;
      cur_q   <= NULLP;
    end else begin
      state_q <= state_d;
      head_q  <= head_d;
      wr_q    <= wr_d;
      cur_q   <= cur_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign inv_valid   = (state_q == ST_WALK) && (cur_q != NULLP);
  assign inv_id      = cur_q;
  assign ack_ready   = inv_valid;
  assign grant_valid = (state_q == ST_GRANT);
  assign grant_id    = wr_q;
  assign head_ptr    = head_q;

  // R7: an unacknowledged invalidate holds its target
  p_inv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !ack_valid) |=> (inv_valid && $stable(inv_id)));
  // R8: grant is a single-cycle pulse
  p_grant_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> !grant_valid);
  // R8: the writer holds the memory head pointer when granted
  p_head_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (head_ptr == grant_id));
  // R5: the writer never receives its own invalidate
  p_inv_not_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_id != wr_q));
  // R4: busy drops only after a grant
  p_busy_ends_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(grant_valid));
endmodule

// File: rtl/llinv_seq.sv
module llinv_seq #(
  parameter int N_CACHE = 6,
  parameter int PTR_W   = $clog2(N_CACHE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [PTR_W-1:0] req_id,
  output logic             busy,
  output logic             inv_valid,
  output logic [PTR_W-1:0] inv_id,
  output logic             ack_ready,
  input  logic             ack_valid,
  output logic             grant_valid,
  output logic [PTR_W-1:0] grant_id,
  output logic [PTR_W-1:0] head_ptr
);
  logic [PTR_W-1:0] lk_id, lk_next, pred_id, cur_id, cur_next;
  logic             lk_present, pred_hit;
  logic             wa_en, wa_pres, wb_en, wb_pres;
  logic [PTR_W-1:0] wa_idx, wa_next, wb_idx, wb_next;

  llinv_table #(.N_CACHE(N_CACHE), .PTR_W(PTR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .lk_id(lk_id), .lk_present(lk_present), .lk_next(lk_next),
    .pred_hit(pred_hit), .pred_id(pred_id),
    .cur_id(cur_id), .cur_next(cur_next),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_next(wa_next), .wa_pres(wa_pres),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_next(wb_next), .wb_pres(wb_pres)
  );

  llinv_ctrl #(.N_CACHE(N_CACHE), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_id(req_id),
    .ack_valid(ack_valid),
    .busy(busy), .inv_valid(inv_valid), .inv_id(inv_id),
    .ack_ready(ack_ready), .grant_valid(grant_valid), .grant_id(grant_id),
    .head_ptr(head_ptr),
    .lk_id(lk_id), .lk_present(lk_present), .lk_next(lk_next),
    .pred_hit(pred_hit), .pred_id(pred_id),
    .cur_id(cur_id), .cur_next(cur_next),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_next(wa_next), .wa_pres(wa_pres),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_next(wb_next), .wb_pres(wb_pres)
  );
endmodule

// File: tb/llinv_seq_test.sv
`timescale 1ns/1ps
module llinv_seq_test;
  localparam int N_CACHE = 6;
  localparam int PTR_W   = $clog2(N_CACHE + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_write, ack_valid;
  logic [PTR_W-1:0] req_id;
  logic             busy, inv_valid, ack_ready, grant_valid;
  logic [PTR_W-1:0] inv_id, grant_id, head_ptr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  llinv_seq #(.N_CACHE(N_CACHE), .PTR_W(PTR_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_id(req_id),
    .busy(busy), .inv_valid(inv_valid), .inv_id(inv_id),
    .ack_ready(ack_ready), .ack_valid(ack_valid),
    .grant_valid(grant_valid), .grant_id(grant_id), .head_ptr(head_ptr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Join request: head moves one cycle later (R2/R3)
  task automatic do_read(input int id, input int exp_head, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_id = PTR_W'(id);
    @(negedge clk);
    req_valid = 1'b0;
    chk(head_ptr == PTR_W'(exp_head), req, "head after read", int'(head_ptr), exp_head);
    chk(busy == 1'b0, req, "busy after read", int'(busy), 0);
  endtask

  // Write request; exp lists expected invalidate order, dly the ack delays.
  // inj != 0 presents a read from cache inj while the first invalidate waits.
  task automatic do_write(input int wid, input int exp[6], input int n,
                          input int dly[6], input int inj);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_id = PTR_W'(wid);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R4", "busy after write", int'(busy), 1);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      chk(inv_valid && inv_id == PTR_W'(exp[k]), "R6", "invalidate target",
          int'(inv_id), exp[k]);
      chk(ack_ready == 1'b1, "R7", "ack_ready with invalidate", int'(ack_ready), 1);
      if (inj != 0 && k == 0) begin
        req_valid = 1'b1; req_write = 1'b0; req_id = PTR_W'(inj);
      end
      for (int d = 0; d < dly[k]; d++) begin
        @(negedge clk);
        req_valid = 1'b0;
        chk(inv_valid && inv_id == PTR_W'(exp[k]), "R7", "invalidate held",
            int'(inv_id), exp[k]);
        chk(busy == 1'b1, "R4", "busy during walk", int'(busy), 1);
      end
      ack_valid = 1'b1;
      @(negedge clk);
      ack_valid = 1'b0;
      req_valid = 1'b0;
    end
    if (n == 0) begin
      chk(inv_valid == 1'b0, "R8", "no invalidate on empty chain", int'(inv_valid), 0);
      @(negedge clk);
    end
    chk(inv_valid == 1'b0, "R8", "walk ended", int'(inv_valid), 0);
    chk(grant_valid == 1'b1 && grant_id == PTR_W'(wid), "R8", "grant id",
        int'(grant_id), wid);
    chk(head_ptr == PTR_W'(wid), "R8", "head at grant", int'(head_ptr), wid);
    @(negedge clk);
    chk(grant_valid == 1'b0, "R8", "grant pulse width", int'(grant_valid), 0);
    chk(busy == 1'b0, "R4", "busy cleared", int'(busy), 0);
  endtask

  task automatic t_reset;
    chk(head_ptr == '0, "R1", "reset head", int'(head_ptr), 0);
    chk(!busy && !inv_valid && !ack_ready && !grant_valid, "R1", "reset outputs",
        int'({busy, inv_valid, ack_ready, grant_valid}), 0);
  endtask

  // Middle splice: chain 3,2,1, writer 2 (R5)
  task automatic t_middle;
    do_read(1, 1, "R2");
    do_read(2, 2, "R2");
    do_read(3, 3, "R2");
    do_write(2, '{3, 1, 0, 0, 0, 0}, 2, '{0, 3, 0, 0, 0, 0}, 0);
  endtask

  // Head splice, and duplicate join ignored: chain 5,4,2, writer 5 (R3, R5)
  task automatic t_head;
    do_read(4, 4, "R2");
    do_read(5, 5, "R2");
    do_read(4, 5, "R3");
    do_write(5, '{4, 2, 0, 0, 0, 0}, 2, '{1, 0, 0, 0, 0, 0}, 0);
  endtask

  // Non-member writer, then repeat write by sole owner (R6, R8)
  task automatic t_outsider;
    do_read(1, 1, "R2");
    do_write(6, '{1, 5, 0, 0, 0, 0}, 2, '{2, 0, 0, 0, 0, 0}, 0);
    do_write(6, '{0, 0, 0, 0, 0, 0}, 0, '{0, 0, 0, 0, 0, 0}, 0);
  endtask

  // Request during busy is dropped (R4)
  task automatic t_busy;
    do_read(3, 3, "R2");
    do_write(4, '{3, 6, 0, 0, 0, 0}, 2, '{2, 1, 0, 0, 0, 0}, 2);
    do_write(1, '{4, 0, 0, 0, 0, 0}, 1, '{0, 0, 0, 0, 0, 0}, 0);
  endtask

  // Stray ack and null ID ignored, then tail splice (R9, R3, R5)
  task automatic t_stray_tail;
    @(negedge clk);
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    chk(head_ptr == PTR_W'(1) && !busy && !grant_valid, "R9", "stray ack head",
        int'(head_ptr), 1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_id = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0, "R3", "null-id write ignored", int'(busy), 0);
    do_read(0, 1, "R3");
    do_read(3, 3, "R2");
    do_write(1, '{3, 0, 0, 0, 0, 0}, 1, '{1, 0, 0, 0, 0, 0}, 0);
  endtask

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_id = '0; ack_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_middle;
    t_head;
    t_outsider;
    t_busy;
    t_stray_tail;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R4: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule